// File: doc/BRIEF.md
# Calendar Time Counter with BCD and 12/24-Hour Modes

This block keeps wall-clock time: seconds, minutes, hours, weekday, date, month, two-digit year and century. A prescaler divides the core clock into a one-second strobe. Each strobe advances the seconds field, and carries ripple up through the calendar within the same cycle. Month lengths follow the Gregorian table. February has 29 days whenever the year field is divisible by 4.

Software reaches the block through a two-address window. A write at the even address selects one of 128 byte indices. Reads and writes at the odd address then reach the selected byte. The byte can be a time field, control register A or B, a fixed flag or status byte, or a general-purpose byte. The fields are held internally in binary with hours in 0–23. The binary/BCD choice and the 12/24-hour choice in control register B are applied each time a field is written or read. Flag and alarm logic live in companion blocks; the alarm bytes here are plain storage.

Top module: `cal_clock`

## Requirements
- R1: A write with addr_i=0 latches wdata_i[6:0] as the index, and bit 7 of wdata_i is ignored. A read with addr_i=0 returns 0xFF. Accesses with addr_i=1 reach the byte at the latched index.
- R2: After reset, register A (index 0x0A) reads 0x26 and register B (index 0x0B) reads 0x02. The time reads 00:00:00 on weekday 1, date 1, month 1, year 0, century 0. Every general-purpose byte reads 0.
- R3: While running, seconds (index 0x00) advance once every TICKS_PER_SEC clock cycles. A seconds value of 59 or more wraps to 0 and carries into minutes (index 0x02). Minutes carry into hours (index 0x04) the same way, and hours carry at 23.
- R4: Date (index 0x07) wraps to 1 after 31, 30 or 28/29 days, depending on month (index 0x08) and year (index 0x09). February has 29 days when year mod 4 is 0. Month 12 wraps to 1 and carries into year. Year 99 wraps to 0 and carries into century (index 0x32), which wraps from 99 to 0.
- R5: Weekday (index 0x06) runs 1 to 7, advances on every day carry and wraps from 7 to 1.
- R6: Register B bit 2 set selects plain binary field values. Clear selects packed BCD, with tens in bits 7:4 and units in bits 3:0. The encoding is applied at each access, so changing the bit reinterprets the stored time.
- R7: Register B bit 1 set gives hours 0–23. Clear gives hours 1–12, where hour 0 reads as 12 and bit 7 is set for hours 12–23. Written hours are decoded the same way.
- R8: While register B bit 7 (SET) is 1, no field advances and time fields take writes. A write to B with bit 7 set forces bit 4 of B to 0.
- R9: Counting needs register A bits 6:4 to be at most 0b010. With A bits 6:5 = 0b11 the prescaler is held. A write that moves A from that state to bits 6:4 ≤ 0b010 makes the first advance TICKS_PER_SEC/2 cycles after the write edge.
- R10: Bit 7 of register A reads 0 and ignores writes. Index 0x0C reads 0x00 and index 0x0D reads 0x80, and both ignore writes.
- R11: Every other index, including 0x01, 0x03, 0x05, 0x0E–0x31 and 0x33–0x7F, is a read/write storage byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe for the current cycle |
| addr_i | input | 1 | 0 selects the index latch, 1 selects the data byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as addr_i and the latched index |

## Verification
A wrong carry or day limit stays hidden until the field crosses that boundary. It then shows as a wrong byte on rdata_o, read right after the advancing strobe. For that reason the stimulus seeds fields just below their limits and checks every field after one or two advances. A wrong prescaler load shows as an advance one or more cycles off the half-second edge, so that edge is sampled on both sides. Encoding faults change the read byte as soon as the mode bit changes, with no clock edge needed.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned IDX_W = 7;
  localparam int unsigned NUM_F = 8;

  localparam logic [IDX_W-1:0] IDX_SEC  = 7'h00;
  localparam logic [IDX_W-1:0] IDX_MIN  = 7'h02;
  localparam logic [IDX_W-1:0] IDX_HOUR = 7'h04;
  localparam logic [IDX_W-1:0] IDX_WDAY = 7'h06;
  localparam logic [IDX_W-1:0] IDX_MDAY = 7'h07;
  localparam logic [IDX_W-1:0] IDX_MON  = 7'h08;
  localparam logic [IDX_W-1:0] IDX_YEAR = 7'h09;
  localparam logic [IDX_W-1:0] IDX_CTLA = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_CTLB = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_FLAG = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_STAT = 7'h0D;
  localparam logic [IDX_W-1:0] IDX_CENT = 7'h32;

  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_WDAY = 3;
  localparam int F_MDAY = 4, F_MON = 5, F_YEAR = 6, F_CENT = 7;

  localparam logic [6:0] CTLA_RST = 7'h26;
  localparam logic [7:0] CTLB_RST = 8'h02;
  localparam logic [7:0] STAT_VAL = 8'h80;
  localparam int B_SET = 7, B_UIE = 4, B_DM = 2, B_H24 = 1;

  function automatic logic [7:0] enc_val(input logic [7:0] v, input logic dm);
    logic [7:0] t, u;
    t = v / 8'd10;
    u = v % 8'd10;
    return dm ? v : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] dec_val(input logic [7:0] b, input logic dm);
    return dm ? b : ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic dm, input logic h24);
    logic [7:0] h12, r;
    if (h24) return enc_val(h, dm);
    h12 = (h >= 8'd12) ? h - 8'd12 : h;
    if (h12 == 8'd0) h12 = 8'd12;
    r = enc_val(h12, dm);
    r[7] = (h >= 8'd12);
    return r;
  endfunction

  function automatic logic [7:0] dec_hour(input logic [7:0] b, input logic dm, input logic h24);
    logic [7:0] v;
    if (h24) return dec_val(b, dm);
    v = dec_val({1'b0, b[6:0]}, dm);
    if (v == 8'd12) v = 8'd0;
    if (b[7]) v = v + 8'd12;
    return v;
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'd2:                         return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:      return 8'd30;
      default:                      return 8'd31;
    endcase
  endfunction

  function automatic logic [7:0] fld_hi(input int i);
    case (i)
      F_SEC, F_MIN:   return 8'd59;
      F_HOUR:         return 8'd23;
      F_WDAY:         return 8'd7;
      F_MON:          return 8'd12;
      default:        return 8'd99;
    endcase
  endfunction

  function automatic logic [7:0] fld_lo(input int i);
    return (i == F_WDAY || i == F_MDAY || i == F_MON) ? 8'd1 : 8'd0;
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST    = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(TICKS_PER_SEC - TICKS_PER_SEC / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= HALF_LD;  // first strobe half a second out
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cal_time_ctr.sv
module cal_time_ctr import cal_pkg::*; (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [NUM_F-1:0]       wr_en_i,
  input  logic [7:0]             wr_val_i,
  output logic [NUM_F-1:0][7:0]  tm_o
);
  logic [NUM_F-1:0] carry;
  logic             unused_carry;

  assign unused_carry = carry[F_WDAY] ^ carry[F_CENT];

  for (genvar i = 0; i < NUM_F; i++) begin : g_fld
    logic [7:0] q, hi;
    logic       cin;

    if (i == F_SEC) begin : g_src_tick
      assign cin = tick_i;
    end else if (i == F_WDAY || i == F_MDAY) begin : g_src_day
      assign cin = carry[F_HOUR];
    end else begin : g_src_prev
      assign cin = carry[i-1];
    end

    if (i == F_MDAY) begin : g_hi_cal
      assign hi = days_in_month(tm_o[F_MON], tm_o[F_YEAR]);
    end else begin : g_hi_fix
      assign hi = fld_hi(i);
    end

    assign carry[i] = cin && (q >= hi);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= fld_lo(i);
      else if (wr_en_i[i]) q <= wr_val_i;
      else if (cin)        q <= (q >= hi) ? fld_lo(i) : q + 8'd1;
    end

    assign tm_o[i] = q;
  end

  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_en_i[F_SEC] && tm_o[F_SEC] < 8'd59 |=> tm_o[F_SEC] == $past(tm_o[F_SEC]) + 8'd1); // R3
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_en_i[F_SEC] && tm_o[F_SEC] >= 8'd59 |=> tm_o[F_SEC] == 8'd0); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && wr_en_i == '0 |=> $stable(tm_o)); // R8
endmodule

// File: rtl/cal_store.sv
module cal_store #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/cal_clock.sv
module cal_clock import cal_pkg::*; #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [IDX_W-1:0]      idx_q;
  logic [6:0]            ctl_a_q;
  logic [7:0]            ctl_b_q;
  logic                  data_wr, restart, div_run, tick, upd;
  logic                  dm, h24, ctl_idx;
  logic [NUM_F-1:0]      fsel, time_we;
  logic [7:0]            time_wval, store_rdata, rd_data;
  logic [NUM_F-1:0][7:0] tm;

  assign data_wr = wr_i && addr_i;
  assign dm      = ctl_b_q[B_DM];
  assign h24     = ctl_b_q[B_H24];

  always_comb begin
    fsel = '0;
    case (idx_q)
      IDX_SEC:  fsel[F_SEC]  = 1'b1;
      IDX_MIN:  fsel[F_MIN]  = 1'b1;
      IDX_HOUR: fsel[F_HOUR] = 1'b1;
      IDX_WDAY: fsel[F_WDAY] = 1'b1;
      IDX_MDAY: fsel[F_MDAY] = 1'b1;
      IDX_MON:  fsel[F_MON]  = 1'b1;
      IDX_YEAR: fsel[F_YEAR] = 1'b1;
      IDX_CENT: fsel[F_CENT] = 1'b1;
      default:  fsel = '0;
    endcase
  end

  assign ctl_idx = (idx_q == IDX_CTLA) || (idx_q == IDX_CTLB) ||
                   (idx_q == IDX_FLAG) || (idx_q == IDX_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      ctl_a_q <= CTLA_RST;
      ctl_b_q <= CTLB_RST;
    end else begin
      if (wr_i && !addr_i) idx_q <= wdata_i[IDX_W-1:0];
      if (data_wr && idx_q == IDX_CTLA) ctl_a_q <= wdata_i[6:0];
      if (data_wr && idx_q == IDX_CTLB)
        ctl_b_q <= wdata_i[B_SET] ? (wdata_i & ~(8'h01 << B_UIE)) : wdata_i;
    end
  end

  // leaving divider reset restarts the prescaler at mid-second
  assign restart = data_wr && (idx_q == IDX_CTLA) && (ctl_a_q[6:5] == 2'b11) &&
                   (wdata_i[6:4] <= 3'b010);
  assign div_run = (ctl_a_q[6:4] <= 3'b010);
  assign upd     = tick && !ctl_b_q[B_SET];

  assign time_we   = data_wr ? fsel : '0;
  assign time_wval = fsel[F_HOUR] ? dec_hour(wdata_i, dm, h24) : dec_val(wdata_i, dm);

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i, .rst_ni, .run_i(div_run), .restart_i(restart), .tick_o(tick)
  );

  cal_time_ctr u_ctr (
    .clk_i, .rst_ni, .tick_i(upd), .wr_en_i(time_we), .wr_val_i(time_wval), .tm_o(tm)
  );

  cal_store #(.AW(IDX_W)) u_store (
    .clk_i, .rst_ni, .we_i(data_wr && fsel == '0 && !ctl_idx),
    .idx_i(idx_q), .wdata_i(wdata_i), .rdata_o(store_rdata)
  );

  always_comb begin
    rd_data = store_rdata;
    for (int i = 0; i < NUM_F; i++)
      if (fsel[i]) rd_data = (i == F_HOUR) ? enc_hour(tm[i], dm, h24) : enc_val(tm[i], dm);
    case (idx_q)
      IDX_CTLA: rd_data = {1'b0, ctl_a_q};
      IDX_CTLB: rd_data = ctl_b_q;
      IDX_FLAG: rd_data = 8'h00;
      IDX_STAT: rd_data = STAT_VAL;
      default:  ;
    endcase
  end

  assign rdata_o = addr_i ? rd_data : 8'hFF;

  AST_SET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_b_q[B_SET] && !data_wr |=> $stable(tm)); // R8
  AST_DIVRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_a_q[6:4] > 3'b010 |-> !tick); // R9
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !tick); // R9
endmodule

// File: tb/sim_cal_clock.sv
`timescale 1ns/1ps
module sim_cal_clock;
  localparam int TPS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m [8];
  int fidx [8] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h32};

  always #5 clk = ~clk;

  cal_clock #(.TICKS_PER_SEC(TPS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] b_enc(input int v, input bit dm);
    return dm ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] b_enc_hour(input int h, input bit dm, input bit h24);
    int hh;
    logic [7:0] r;
    if (h24) return b_enc(h, dm);
    hh = h % 12;
    if (hh == 0) hh = 12;
    r = b_enc(hh, dm);
    if (h >= 12) r = r | 8'h80;
    return r;
  endfunction

  function automatic int b_dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0;
          m[3] = (m[3] == 7) ? 1 : m[3] + 1;
          m[4]++;
          if (m[4] > b_dim(m[5], m[6])) begin
            m[4] = 1; m[5]++;
            if (m[5] == 13) begin
              m[5] = 1; m[6]++;
              if (m[6] == 100) begin
                m[6] = 0;
                m[7] = (m[7] + 1) % 100;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr = 1'b0; addr = 1'b1;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] v);
    bus_wr(1'b0, idx);
    bus_wr(1'b1, v);
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [7:0] v);
    bus_wr(1'b0, idx);
    @(negedge clk);
    v = rdata;
  endtask

  // loads m[] with SET and divider reset, restarts, waits n advances, reads back
  task automatic run_case(input bit dm, input bit h24, input int n);
    logic [7:0] v;
    string tags [8] = '{"R3/R6 sec", "R3/R6 min", "R7 hour", "R5 wday",
                        "R4/R6 mday", "R4/R6 mon", "R4/R6 year", "R4/R6 cent"};
    wreg(8'h0A, 8'h76);
    wreg(8'h0B, 8'h80 | (8'(dm) << 2) | (8'(h24) << 1));
    for (int i = 0; i < 8; i++)
      wreg(8'(fidx[i]), (i == 2) ? b_enc_hour(m[2], dm, h24) : b_enc(m[i], dm));
    wreg(8'h0B, (8'(dm) << 2) | (8'(h24) << 1));
    wreg(8'h0A, 8'h26);
    repeat (TPS / 2 + TPS * (n - 1)) @(posedge clk);
    for (int k = 0; k < n; k++) model_step();
    for (int i = 0; i < 8; i++) begin
      rreg(8'(fidx[i]), v);
      chk(tags[i], v, (i == 2) ? b_enc_hour(m[2], dm, h24) : b_enc(m[i], dm));
    end
    // flip encoding under SET, force 24h: stored hour is reinterpreted (R6 R7)
    wreg(8'h0B, 8'h82 | (8'(!dm) << 2));
    rreg(8'h04, v);
    chk("R6/R7 hour reinterpret", v, b_enc(m[2], !dm));
  endtask

  function automatic int pick(input int lo, input int hi);
    return ($urandom_range(2) == 0) ? hi : int'($urandom_range(hi, lo));
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state
    rreg(8'h0A, v); chk("R2 ctl A", v, 8'h26);
    rreg(8'h0B, v); chk("R2 ctl B", v, 8'h02);
    rreg(8'h0C, v); chk("R10 flag byte", v, 8'h00);
    rreg(8'h0D, v); chk("R10 status byte", v, 8'h80);
    rreg(8'h00, v); chk("R2 sec", v, 8'h00);
    rreg(8'h07, v); chk("R2 date", v, 8'h01);
    rreg(8'h06, v); chk("R2 wday", v, 8'h01);
    rreg(8'h20, v); chk("R2 store", v, 8'h00);
    @(negedge clk); addr = 1'b0; #1; chk("R1 even read", rdata, 8'hFF); addr = 1'b1;

    // R1 R11 index latch and storage
    wreg(8'h8E, 8'hA5);
    rreg(8'h0E, v); chk("R1 index bit7 ignored", v, 8'hA5);
    wreg(8'h01, 8'h3C); rreg(8'h01, v); chk("R11 alarm byte", v, 8'h3C);
    wreg(8'h7F, 8'hC3); rreg(8'h7F, v); chk("R11 top byte", v, 8'hC3);
    // R10 read-only bytes
    wreg(8'h0C, 8'h55); rreg(8'h0C, v); chk("R10 flag write ignored", v, 8'h00);
    wreg(8'h0D, 8'h11); rreg(8'h0D, v); chk("R10 status write ignored", v, 8'h80);
    wreg(8'h0A, 8'hA6); rreg(8'h0A, v); chk("R10 A bit7", v, 8'h26);

    // R9 half-second first advance
    wreg(8'h0A, 8'h76);
    wreg(8'h0B, 8'h82);
    wreg(8'h00, 8'h10);
    wreg(8'h0B, 8'h02);
    wreg(8'h0A, 8'h26);
    bus_wr(1'b0, 8'h00);
    repeat (TPS / 2 - 2) @(posedge clk);
    @(negedge clk); chk("R9 before half second", rdata, 8'h10);
    @(posedge clk);
    @(negedge clk); chk("R9 at half second", rdata, 8'h11);

    // R9 divider reset holds time
    wreg(8'h0A, 8'h76);
    rreg(8'h00, s0);
    repeat (3 * TPS) @(posedge clk);
    rreg(8'h00, v); chk("R9 divider hold", v, s0);

    // R8 SET freezes time, UIE forced low
    wreg(8'h0B, 8'h82);
    wreg(8'h0A, 8'h26);
    rreg(8'h00, s0);
    repeat (3 * TPS) @(posedge clk);
    rreg(8'h00, v); chk("R8 SET hold", v, s0);
    wreg(8'h0B, 8'h92);
    rreg(8'h0B, v); chk("R8 UIE cleared", v, 8'h82);

    // directed calendar corners
    m = '{59, 59, 23, 7, 28, 2, 24, 20}; run_case(1'b0, 1'b0, 1); // R4 leap Feb, R7 midnight
    m = '{59, 59, 23, 3, 28, 2, 23, 20}; run_case(1'b0, 1'b1, 1); // R4 common Feb
    m = '{59, 59, 23, 5, 30, 4, 10, 20}; run_case(1'b1, 1'b1, 1); // R4 30-day month
    m = '{58, 59, 23, 6, 31, 12, 99, 19}; run_case(1'b1, 1'b0, 2); // R4 year and century
    m = '{59, 59, 11, 2, 15, 6, 5, 99}; run_case(1'b0, 1'b0, 1);  // R7 noon

    // constrained random
    for (int it = 0; it < 14; it++) begin
      bit dm, h24;
      dm = 1'($urandom_range(1));
      h24 = 1'($urandom_range(1));
      m[0] = pick(0, 59);
      m[1] = pick(0, 59);
      m[2] = pick(0, 23);
      m[3] = pick(1, 7);
      m[5] = pick(1, 12);
      m[6] = ($urandom_range(1) == 1) ? 4 * int'($urandom_range(24)) : pick(0, 99);
      m[4] = pick(1, b_dim(m[5], m[6]));
      m[7] = pick(0, 99);
      run_case(dm, h24, 1 + int'($urandom_range(1)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule